// File: doc/BRIEF.md
# Three-State Phase/Frequency Detector with Programmable Sense

This block is a synchronous model of a phase/frequency detector for a frequency synthesizer loop. It runs in a fast system clock domain. It takes two single-cycle edge events: one from the reference divider and one from the feedback divider. From these it produces pump-up and pump-down requests for a charge pump.

A reference edge arms the "up" state and a feedback edge arms the "down" state. When both states are armed, both stay active for a programmable overlap window and then clear together. Because of this, two coincident edges still give a short pulse on both outputs, so the detector has no dead zone. A repeated edge on an input that is already armed changes nothing. This makes the detector behave as a frequency detector when the error exceeds one cycle, and gives it a full range of −2π to +2π.

A sense bit swaps the two outputs, so the block suits VCOs with either tuning slope. A lock flag rises after a run of consecutive comparisons in which neither request outlasted the overlap window by more than one clock.

Top module: `phase_det_top`

## Requirements
- R1: A reference edge makes the up state active from the next clock. A feedback edge does the same for the down state. With `invertSense`=0, the up state drives `pumpUp` and the down state drives `pumpDown`.
- R2: With `invertSense`=1, `pumpUp` shows the down state and `pumpDown` shows the up state.
- R3: Once both states are active, both outputs stay high for exactly `overlapLen` clocks. An `overlapLen` of 0 acts as 1. Both outputs then fall on the same clock.
- R4: A reference edge and a feedback edge in the same clock make both outputs high for exactly `overlapLen` clocks (0 acts as 1). There is no dead zone.
- R5: A further edge on an input whose state is already active has no effect. The state stays active until the other input's edge completes the comparison.
- R6: An edge that arrives on the clock where both states clear starts a new comparison. Its state is active on the next clock.
- R7: A comparison is good when the span from the first active clock to the clearing clock is at most `overlapLen`+1 clocks. `locked` rises on the clock after the clearing of the 16th consecutive good comparison.
- R8: A comparison whose span is longer than `overlapLen`+1 clocks drops `locked` at its clearing and restarts the count of good comparisons.
- R9: While reset is held, and right after it is released, `pumpUp`, `pumpDown` and `locked` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| refEdge | input | 1 | One-cycle event from the reference divider |
| fbEdge | input | 1 | One-cycle event from the feedback divider |
| invertSense | input | 1 | 1 swaps the up and down outputs |
| overlapLen | input | OVL_W (4) | Overlap window in clocks; 0 acts as 1 |
| pumpUp | output | 1 | Pump-up request |
| pumpDown | output | 1 | Pump-down request |
| locked | output | 1 | Lock indication |

## Verification
The bench applies edge patterns to the detector and compares them with a bench model computed from the requirements:
- **Coincident edges** expose a dead zone or a wrong overlap length.
- **Edges a fixed offset apart**, with the reference leading or lagging, separate up requests from down requests and test the sense swap.
- **Unequal reference and feedback periods** test that a repeated edge keeps its state armed, as frequency detection needs.
- **Runs of tight comparisons, followed by one wide comparison,** show that `locked` rises after exactly the right count and falls on a wide span.

// File: rtl/phase_det_pkg.sv
package phase_det_pkg;
  typedef struct packed {
    logic setUp;
    logic setDn;
    logic clear;
  } detStrobe_t;
endpackage

// File: rtl/phase_det_datapath.sv
module phase_det_datapath
  import phase_det_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  detStrobe_t strb,
  input  logic       invertSense,
  output logic       upState,
  output logic       dnState,
  output logic       pumpUp,
  output logic       pumpDown
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upState <= 1'b0;
      dnState <= 1'b0;
    end else begin
      upState <= strb.setUp | (upState & ~strb.clear);
      dnState <= strb.setDn | (dnState & ~strb.clear);
    end
  end

  always_comb begin
    pumpUp   = invertSense ? dnState : upState;
    pumpDown = invertSense ? upState : dnState;
  end

  AST_UP_ARM: assert property (@(posedge clk) disable iff (!rstN) strb.setUp |=> upState); // R1
  AST_DN_ARM: assert property (@(posedge clk) disable iff (!rstN) strb.setDn |=> dnState); // R1
  AST_ARMED_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (upState && !strb.clear) |=> upState); // R5
  AST_JOINT_FALL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(upState) |-> (!dnState || $past(strb.setDn))); // R3
endmodule

// File: rtl/phase_det_control.sv
module phase_det_control
  import phase_det_pkg::*;
#(
  parameter int OVL_W  = 4,
  parameter int LOCK_N = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             refEdge,
  input  logic             fbEdge,
  input  logic [OVL_W-1:0] overlapLen,
  input  logic             upState,
  input  logic             dnState,
  output detStrobe_t       strb,
  output logic             locked
);
  localparam int ACT_W = OVL_W + 2;
  localparam int CNT_W = $clog2(LOCK_N + 1);
  localparam logic [CNT_W-1:0] LOCK_MAX = CNT_W'(LOCK_N);

  logic [OVL_W-1:0] lenEff;
  logic [OVL_W-1:0] ovlCnt;
  logic [ACT_W-1:0] activeCnt;
  logic [CNT_W-1:0] goodCnt;
  logic bothSet, anySet, clearNow, spanGood;

  always_comb begin
    lenEff   = (overlapLen == '0) ? OVL_W'(1) : overlapLen;
    bothSet  = upState & dnState;
    anySet   = upState | dnState;
    clearNow = bothSet && (ovlCnt >= lenEff - OVL_W'(1));
    spanGood = activeCnt <= {2'b00, lenEff};
    strb.setUp = refEdge;
    strb.setDn = fbEdge;
    strb.clear = clearNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovlCnt    <= '0;
      activeCnt <= '0;
      goodCnt   <= '0;
    end else begin
      if (clearNow || !bothSet) ovlCnt <= '0;
      else                      ovlCnt <= ovlCnt + OVL_W'(1);

      if (clearNow)                      activeCnt <= '0;
      else if (anySet && (activeCnt != '1)) activeCnt <= activeCnt + ACT_W'(1);

      if (clearNow) begin
        if (!spanGood)              goodCnt <= '0;
        else if (goodCnt != LOCK_MAX) goodCnt <= goodCnt + CNT_W'(1);
      end
    end
  end

  assign locked = (goodCnt == LOCK_MAX);

  AST_NO_DEADZONE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(bothSet) |-> $past(clearNow)); // R4
  AST_LOCK_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    goodCnt <= LOCK_MAX); // R7
  AST_LOCK_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (clearNow && !spanGood) |=> !locked); // R8
  AST_LOCK_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> $past(clearNow)); // R7
endmodule

// File: rtl/phase_det_top.sv
module phase_det_top
  import phase_det_pkg::*;
#(
  parameter int OVL_W  = 4,
  parameter int LOCK_N = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             refEdge,
  input  logic             fbEdge,
  input  logic             invertSense,
  input  logic [OVL_W-1:0] overlapLen,
  output logic             pumpUp,
  output logic             pumpDown,
  output logic             locked
);
  detStrobe_t strb;
  logic upState, dnState;

  phase_det_control #(.OVL_W(OVL_W), .LOCK_N(LOCK_N)) u_ctrl (
    .clk(clk), .rstN(rstN), .refEdge(refEdge), .fbEdge(fbEdge),
    .overlapLen(overlapLen), .upState(upState), .dnState(dnState),
    .strb(strb), .locked(locked)
  );

  phase_det_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .invertSense(invertSense),
    .upState(upState), .dnState(dnState), .pumpUp(pumpUp), .pumpDown(pumpDown)
  );
endmodule

// File: tb/phase_det_top_tb.sv
module phase_det_top_tb;
  logic clk = 0, rstN = 0, refEdge = 0, fbEdge = 0, invertSense = 0;
  logic [3:0] overlapLen = 4'd2;
  logic pumpUp, pumpDown, locked;
  int total = 0, bad = 0;
  bit cmpOn = 0;

  always #5 clk = ~clk;

  phase_det_top u_dut (.clk(clk), .rstN(rstN), .refEdge(refEdge), .fbEdge(fbEdge),
    .invertSense(invertSense), .overlapLen(overlapLen),
    .pumpUp(pumpUp), .pumpDown(pumpDown), .locked(locked));

  // bench model built from the requirements
  bit mUp, mDn;
  int mBoth, mSpan, mGood;
  function automatic int effLen(input logic [3:0] l);
    return (l == 0) ? 1 : int'(l);
  endfunction
  function automatic bit expUp(input bit u, input bit d, input bit inv);
    return inv ? d : u;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mUp = 0; mDn = 0; mBoth = 0; mSpan = 0; mGood = 0;
    end else begin
      bit clr;
      clr = 0;
      if (mUp || mDn) mSpan++;
      if (mUp && mDn) begin
        mBoth++;
        if (mBoth >= effLen(overlapLen)) clr = 1;
      end
      if (clr) begin
        if (mSpan <= effLen(overlapLen) + 1) mGood = (mGood < 16) ? mGood + 1 : 16;
        else mGood = 0;
        mUp = 0; mDn = 0; mBoth = 0; mSpan = 0;
      end
      if (refEdge) mUp = 1;
      if (fbEdge) mDn = 1;
    end
  end

  task automatic check(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (cmpOn) begin
    check("R1 R2 pumpUp", pumpUp, expUp(mUp, mDn, invertSense));
    check("R1 R2 pumpDown", pumpDown, expUp(mDn, mUp, invertSense));
    check("R7 R8 locked", locked, mGood == 16);
  end

  task automatic cyc(input bit r, input bit f);
    refEdge = r; fbEdge = f;
    @(negedge clk);
    refEdge = 0; fbEdge = 0;
  endtask

  task automatic drain();
    if (pumpUp || pumpDown) cyc(1, 1);
    while (pumpUp || pumpDown) cyc(0, 0);
  endtask

  task automatic countHigh(input string tag, input int exp);
    int n = 0;
    while (pumpUp && n < 40) begin
      n++; cyc(0, 0);
    end
    total++;
    if (n != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, n, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    check("R9 reset pumpUp", pumpUp, 0);
    check("R9 reset pumpDown", pumpDown, 0);
    check("R9 reset locked", locked, 0);
    repeat (2) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check("R9 after release locked", locked, 0);
    cmpOn = 1;

    // R4: coincident edges give an overlap pulse of the programmed width
    overlapLen = 3; cyc(1, 1);
    check("R4 pumpDown coincident", pumpDown, 1);
    countHigh("R4 width 3", 3);
    // R3: zero acts as one
    overlapLen = 0; cyc(1, 1);
    countHigh("R3 width 0->1", 1);
    overlapLen = 2;
    // R3: lagging feedback, both fall together after 2 overlap clocks
    cyc(1, 0); cyc(0, 0); cyc(0, 1);
    check("R3 both high", pumpDown, 1);
    cyc(0, 0);
    check("R3 still both", pumpDown & pumpUp, 1);
    cyc(0, 0);
    check("R3 joint fall", pumpUp | pumpDown, 0);
    // R2: sense swap
    invertSense = 1; cyc(1, 0);
    check("R2 ref shows on pumpDown", pumpDown, 1);
    check("R2 pumpUp idle", pumpUp, 0);
    drain(); invertSense = 0;
    // R5: repeated ref edge ignored
    cyc(1, 0); cyc(0, 0); cyc(1, 0); cyc(0, 0); cyc(1, 0);
    check("R5 up still armed", pumpUp, 1);
    check("R5 down idle", pumpDown, 0);
    drain();
    // R6: edge on the clearing clock starts a new comparison
    overlapLen = 1; cyc(1, 1); cyc(1, 0);
    check("R6 new up armed", pumpUp, 1);
    check("R6 down clear", pumpDown, 0);
    drain();
    // R7: sixteen tight comparisons lock
    overlapLen = 2;
    for (int i = 0; i < 16; i++) begin
      cyc(1, 1); cyc(0, 0); cyc(0, 0);
    end
    check("R7 locked after 16", locked, 1);
    // R8: one wide comparison drops lock
    cyc(1, 0); repeat (4) cyc(0, 0); cyc(0, 1); cyc(0, 0); cyc(0, 0);
    check("R8 lock dropped", locked, 0);

    // random phase and frequency runs against the model
    for (int b = 0; b < 60; b++) begin
      int pr, pf, off;
      drain();
      overlapLen = 4'($urandom_range(0, 3));
      invertSense = 1'($urandom_range(0, 1));
      pr = $urandom_range(6, 14);
      pf = ($urandom_range(0, 2) == 0) ? pr + $urandom_range(0, 2) - 1 : pr;
      off = $urandom_range(0, 4);
      for (int c = 0; c < 150; c++) cyc((c % pr) == 0, ((c + off) % pf) == 0);
    end
    drain();
    cmpOn = 0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule